// File: doc/BRIEF.md
# Multi-Operand Prefix-Sum Unit

This unit is a shared fetch-and-add engine for a cluster of thread processors. Each processor port can raise a request carrying an increment. In one clock the unit accepts every raised request together and treats the batch as one atomic operation on a single base register. Each granted port receives the base value plus the increments of all granted ports ranked ahead of it. The base register then moves forward by the sum of all granted increments.

Ports are ranked by ascending index, so port 0 is always first. Software must not rely on that order; only the consistency with one sequential order is part of the contract. The common use is slot allocation: every requester adds 1 and uses the returned value as a private index.

A load port writes the base register directly. The running prefix is computed by a parameterised scan network, either a logarithmic-depth parallel scan or a linear ripple chain. Results are registered and appear one cycle after the request.

Top module: `mps_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every response valid is 0, and the base register holds 0.
- R2: When no load happened in the previous cycle, `rsp_vld` equals the `req_vld` vector of the previous cycle.
- R3: The lowest-indexed granted port receives the base value as it was before the operation.
- R4: A granted port i receives the old base plus the sum of the increments of all granted ports with index below i. Port i occupies bits [i*WIDTH +: WIDTH] of `req_inc` and `rsp_val`.
- R5: The increment of a port whose request is not valid adds nothing to any result or to the base.
- R6: After an operation the base holds its old value plus the sum of all granted increments.
- R7: With `load_en` high the base takes `load_val` on the next edge. Requests in that cycle get no response and do not change the base.
- R8: A cycle with no request and no load leaves the base unchanged.
- R9: If every port requests with increment 1, the ports receive consecutive, distinct values starting at the old base.
- R10: All sums wrap modulo 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write `load_val` into the base register |
| load_val | input | WIDTH | Value to load |
| req_vld | input | NPORT | Per-port request valid |
| req_inc | input | NPORT*WIDTH | Per-port increment |
| rsp_vld | output | NPORT | Per-port response valid, one cycle after the request |
| rsp_val | output | NPORT*WIDTH | Per-port returned prefix value |

## Verification
The bench sweeps all request masks of a four-port, six-bit configuration against many increment patterns. Both scan variants run side by side. A scan shifted by one position would hand a port its own increment, and a missing mask would let idle ports push later ports and the base forward. Loads arrive with requests pending, which catches a design that lets those requests through or ignores the load. Near the top of the range, the all-ones allocation case shows whether sums wrap or saturate.

// File: rtl/mps_pkg.sv
package mps_pkg;
    typedef enum logic [0:0] {
        SCAN_LOG    = 1'b0,
        SCAN_RIPPLE = 1'b1
    } scan_arch_e;
endpackage

// File: rtl/mps_gate.sv
module mps_gate #(
    parameter int NPORT = 8,
    parameter int WIDTH = 16
) (
    input  logic                   hold,
    input  logic [NPORT-1:0]       vld,
    input  logic [NPORT*WIDTH-1:0] inc,
    output logic [NPORT*WIDTH-1:0] term
);
    for (genvar g = 0; g < NPORT; g++) begin : g_port
        assign term[g*WIDTH +: WIDTH] = (vld[g] && !hold) ? inc[g*WIDTH +: WIDTH] : '0;
    end
endmodule

// File: rtl/mps_scan.sv
module mps_scan #(
    parameter int                  NPORT = 8,
    parameter int                  WIDTH = 16,
    parameter mps_pkg::scan_arch_e ARCH  = mps_pkg::SCAN_LOG
) (
    input  logic [NPORT*WIDTH-1:0] term,
    output logic [NPORT*WIDTH-1:0] excl,
    output logic [WIDTH-1:0]       total
);
    localparam int STAGES = (NPORT > 1) ? $clog2(NPORT) : 1;

    if (ARCH == mps_pkg::SCAN_LOG) begin : g_log
        logic [WIDTH-1:0] lvl [0:STAGES][0:NPORT-1];
        for (genvar p = 0; p < NPORT; p++) begin : g_in
            assign lvl[0][p] = term[p*WIDTH +: WIDTH];
        end
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            for (genvar p = 0; p < NPORT; p++) begin : g_node
                if (p >= (1 << s)) begin : g_add
                    assign lvl[s+1][p] = lvl[s][p] + lvl[s][p - (1 << s)];
                end else begin : g_pass
                    assign lvl[s+1][p] = lvl[s][p];
                end
            end
        end
        assign excl[WIDTH-1:0] = '0;
        for (genvar p = 1; p < NPORT; p++) begin : g_out
            assign excl[p*WIDTH +: WIDTH] = lvl[STAGES][p-1];
        end
        assign total = lvl[STAGES][NPORT-1];
    end else begin : g_ripple
        logic [WIDTH-1:0] run [0:NPORT];
        assign run[0] = '0;
        for (genvar p = 0; p < NPORT; p++) begin : g_chain
            assign run[p+1]               = run[p] + term[p*WIDTH +: WIDTH];
            assign excl[p*WIDTH +: WIDTH] = run[p];
        end
        assign total = run[NPORT];
    end
endmodule

// File: rtl/mps_unit.sv
module mps_unit #(
    parameter int                  NPORT     = 8,
    parameter int                  WIDTH     = 16,
    parameter mps_pkg::scan_arch_e SCAN_ARCH = mps_pkg::SCAN_LOG
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_en,
    input  logic [WIDTH-1:0]       load_val,
    input  logic [NPORT-1:0]       req_vld,
    input  logic [NPORT*WIDTH-1:0] req_inc,
    output logic [NPORT-1:0]       rsp_vld,
    output logic [NPORT*WIDTH-1:0] rsp_val
);
    typedef struct packed {
        logic [WIDTH-1:0]       base;
        logic [NPORT-1:0]       vld;
        logic [NPORT*WIDTH-1:0] val;
    } state_t;

    state_t                 st_d, st_q;
    logic [NPORT*WIDTH-1:0] term, excl;
    logic [WIDTH-1:0]       sum_all;
    logic [WIDTH-1:0]       base_q;

    mps_gate #(.NPORT(NPORT), .WIDTH(WIDTH)) u_gate (
        .hold (load_en),
        .vld  (req_vld),
        .inc  (req_inc),
        .term (term)
    );

    mps_scan #(.NPORT(NPORT), .WIDTH(WIDTH), .ARCH(SCAN_ARCH)) u_scan (
        .term  (term),
        .excl  (excl),
        .total (sum_all)
    );

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.base = load_val;
            st_d.vld  = '0;
        end else begin
            st_d.base = st_q.base + sum_all;
            st_d.vld  = req_vld;
            for (int p = 0; p < NPORT; p++) begin
                st_d.val[p*WIDTH +: WIDTH] = st_q.base + excl[p*WIDTH +: WIDTH];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_q  = st_q.base;
    assign rsp_vld = st_q.vld;
    assign rsp_val = st_q.val;
endmodule

// File: rtl/mps_unit_chk.sv
module mps_unit_chk #(
    parameter int NPORT = 8,
    parameter int WIDTH = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   load_en,
    input logic [WIDTH-1:0]       load_val,
    input logic [NPORT-1:0]       req_vld,
    input logic [NPORT*WIDTH-1:0] req_inc,
    input logic [NPORT-1:0]       rsp_vld,
    input logic [NPORT*WIDTH-1:0] rsp_val,
    input logic [WIDTH-1:0]       base_q
);
    logic past_ok_q;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !past_ok_q |-> (rsp_vld == '0));

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && !$past(load_en) |-> rsp_vld == $past(req_vld));

    assert_first_gets_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && !$past(load_en) && rsp_vld[0] |-> rsp_val[WIDTH-1:0] == $past(base_q));

    assert_load_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(load_en) |-> (rsp_vld == '0) && (base_q == $past(load_val)));

    assert_idle_keeps_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && !$past(load_en) && ($past(req_vld) == '0) |-> $stable(base_q));

    for (genvar p = 1; p < NPORT; p++) begin : g_step
        assert_prefix_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok_q && !$past(load_en) && rsp_vld[p] && $past(req_vld[p-1])
            |-> rsp_val[p*WIDTH +: WIDTH] ==
                rsp_val[(p-1)*WIDTH +: WIDTH] + $past(req_inc[(p-1)*WIDTH +: WIDTH]));

        assert_idle_adds_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok_q && !$past(load_en) && rsp_vld[p] && !$past(req_vld[p-1])
            |-> rsp_val[p*WIDTH +: WIDTH] == rsp_val[(p-1)*WIDTH +: WIDTH]);
    end
endmodule

bind mps_unit mps_unit_chk #(.NPORT(NPORT), .WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .load_val (load_val),
    .req_vld  (req_vld),
    .req_inc  (req_inc),
    .rsp_vld  (rsp_vld),
    .rsp_val  (rsp_val),
    .base_q   (base_q)
);

// File: tb/mps_unit_bench.sv
`timescale 1ns/1ps
module mps_unit_bench;
    localparam int N = 4;
    localparam int W = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           load_en = 1'b0;
    logic [W-1:0]   load_val = '0;
    logic [N-1:0]   req_vld = '0;
    logic [N*W-1:0] req_inc = '0;
    logic [N-1:0]   rv_a, rv_b;
    logic [N*W-1:0] rval_a, rval_b;

    int           total_c = 0;
    int           bad_c = 0;
    logic [W-1:0] model_base = '0;

    always #2.5 clk = ~clk;

    mps_unit #(.NPORT(N), .WIDTH(W), .SCAN_ARCH(mps_pkg::SCAN_LOG)) u_mps_unit (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
        .req_vld(req_vld), .req_inc(req_inc), .rsp_vld(rv_a), .rsp_val(rval_a)
    );

    mps_unit #(.NPORT(N), .WIDTH(W), .SCAN_ARCH(mps_pkg::SCAN_RIPPLE)) u_mps_unit_rip (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
        .req_vld(req_vld), .req_inc(req_inc), .rsp_vld(rv_b), .rsp_val(rval_b)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total_c++;
        if (act !== exp) begin
            bad_c++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [N-1:0] m, input logic [N*W-1:0] inc, input string tag);
        logic [N*W-1:0] expv = '0;
        logic [N*W-1:0] wm = '0;
        logic [W-1:0]   acc = model_base;
        for (int i = 0; i < N; i++) begin
            if (m[i]) begin
                expv[i*W +: W] = acc;
                wm[i*W +: W]   = '1;
                acc            = acc + inc[i*W +: W];
            end
        end
        @(negedge clk);
        req_vld = m;
        req_inc = inc;
        @(posedge clk);
        #1;
        check("R2 log", 64'(rv_a), 64'(m));
        check("R2 ripple", 64'(rv_b), 64'(m));
        check({tag, " log"}, 64'(rval_a & wm), 64'(expv));
        check({tag, " ripple"}, 64'(rval_b & wm), 64'(expv));
        model_base = acc;
        @(negedge clk);
        req_vld = '0;
    endtask

    task automatic probe(input string tag);
        run_op(4'b0001, '0, tag);
    endtask

    task automatic do_load(input logic [W-1:0] v, input logic [N-1:0] m);
        @(negedge clk);
        load_en  = 1'b1;
        load_val = v;
        req_vld  = m;
        req_inc  = {6'd7, 6'd9, 6'd11, 6'd13};
        @(posedge clk);
        #1;
        check("R7 log vld", 64'(rv_a), 64'd0);
        check("R7 ripple vld", 64'(rv_b), 64'd0);
        @(negedge clk);
        load_en = 1'b0;
        req_vld = '0;
        model_base = v;
        probe("R7");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 log vld", 64'(rv_a), 64'd0);
        check("R1 ripple vld", 64'(rv_b), 64'd0);
        rst_n = 1'b1;
        run_op(4'b0001, {6'd0, 6'd0, 6'd0, 6'd5}, "R1");

        // R3 R4 R5 R6: all masks over many increment patterns
        for (int seed = 0; seed < 32; seed++) begin
            for (int m = 0; m < 16; m++) begin
                logic [N*W-1:0] inc;
                for (int i = 0; i < N; i++)
                    inc[i*W +: W] = W'((seed * 7 + i * 5 + m * 3 + 3) % 64);
                run_op(N'(m), inc, "R3 R4 R5");
                if (m % 5 == 0) probe("R6");
            end
        end

        // R8: idle cycle with increments present but no request
        @(negedge clk);
        req_vld = '0;
        req_inc = '1;
        @(posedge clk);
        @(negedge clk);
        probe("R8");

        // R7: load with all ports requesting
        do_load(6'd17, 4'b1111);

        // R9: allocation from a loaded base
        do_load(6'd10, 4'b0000);
        run_op(4'b1111, {6'd1, 6'd1, 6'd1, 6'd1}, "R9");
        probe("R9");

        // R10: wrap around the top of the range
        do_load(6'h3E, 4'b0101);
        run_op(4'b1111, {6'd1, 6'd1, 6'd1, 6'd1}, "R10");
        check("R10 model", 64'(model_base), 64'd2);
        probe("R10");

        $display("test done: total=%0d bad=%0d", total_c, bad_c);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total_c++;
        bad_c++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total_c, bad_c);
        $finish;
    end
endmodule